// File: doc/BRIEF.md
# Operand-Isolated Compare/Add Datapath

This block is a small arithmetic datapath that holds two unsigned operands and returns one of two results: a one-bit "first operand is larger" comparison, or the full sum with its carry. A per-operation select input names the unit whose result is wanted. That result is captured in an output register. The output register loads only on cycles that carry a valid operation.

Each functional unit is fed through a bank of transparent latches. A latch bank opens only while its own unit is selected. The unselected unit therefore sees frozen inputs and does not toggle. The latched operand pairs of both units are brought out as ports, so the freezing can be observed from outside the block.

An operation presented with `in_valid` high before clock edge k is captured at edge k. The selected unit's operand port shows the captured pair after edge k. The result appears on `res_out` after edge k+1.

Top module: `guarded_cmp_add`

## Requirements
- R1: `a_in`, `b_in` and `sel` are captured at a clock edge only when `in_valid` is high. Values presented with `in_valid` low have no effect on any output.
- R2: When a captured operation has `sel` = 0, `res_out` after the following edge equals 1 if `a_in` > `b_in` (unsigned) and 0 otherwise, zero-extended to W+1 bits.
- R3: When a captured operation has `sel` = 1, `res_out` after the following edge equals `a_in` + `b_in` as a W+1 bit value, with the carry in bit W.
- R4: The select encoding is fixed: `sel` = 0 picks the comparator and `sel` = 1 picks the adder.
- R5: `cmp_opnd` = {a, b} changes only after the edge that captures an operation with `sel` = 0. It holds its value across add operations and idle cycles.
- R6: `add_opnd` = {a, b} changes only after the edge that captures an operation with `sel` = 1. It holds its value across compare operations and idle cycles.
- R7: After the edge that captures an operation, the operand port of the selected unit shows that operation's {a_in, b_in}.
- R8: `res_out` holds its value after any edge that follows a cycle with no captured operation.
- R9: The synchronous active-high `rst` clears `res_out`, `cmp_opnd` and `add_opnd` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on a_in, b_in, sel |
| sel | input | 1 | 0 = compare, 1 = add |
| a_in | input | W | First operand, unsigned |
| b_in | input | W | Second operand, unsigned |
| res_out | output | W+1 | Registered selected result |
| cmp_opnd | output | 2W | Comparator's latched operands {a, b} |
| add_opnd | output | 2W | Adder's latched operands {a, b} |

## Verification
The bench builds the block with W = 8. At that width the extreme operands 255 + 255 bring the carry bit into reach, and random pairs often enough land on equal or near-equal values at the comparator's boundary. Random runs mix valid, idle, compare and add cycles back to back. This exposes the frozen operand ports to every ordering of selections, including long runs that stay on one unit.

// File: rtl/gca_pkg.sv
package gca_pkg;
  typedef enum logic {
    UNIT_CMP = 1'b0,
    UNIT_ADD = 1'b1
  } unit_sel_e;
  localparam int NUM_UNITS = 2;
endpackage

// File: rtl/gca_in_stage.sv
module gca_in_stage
  import gca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         vld_q,
  output unit_sel_e    sel_q,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sel_q <= UNIT_CMP;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        sel_q <= unit_sel_e'(sel);
        a_q   <= a_in;
        b_q   <= b_in;
      end
    end
  end
endmodule

// File: rtl/gca_iso_latch.sv
module gca_iso_latch #(
  parameter int DW = 16
) (
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_latch begin
    if (en) q = d;
  end
endmodule

// File: rtl/gca_units.sv
module gca_gt_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt
);
  always_comb gt = (a > b);
endmodule

module gca_sum_unit #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);
  always_comb sum = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/gca_out_stage.sv
module gca_out_stage
  import gca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld_q,
  input  unit_sel_e  sel_q,
  input  logic       gt,
  input  logic [W:0] sum,
  output logic [W:0] res_out
);
  logic [W:0] pick;
  always_comb pick = (sel_q == UNIT_ADD) ? sum : {{W{1'b0}}, gt};

  always_ff @(posedge clk) begin
    if (rst)        res_out <= '0;
    else if (vld_q) res_out <= pick;
  end
endmodule

// File: rtl/guarded_cmp_add.sv
module guarded_cmp_add
  import gca_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic           sel,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic [W:0]     res_out,
  output logic [2*W-1:0] cmp_opnd,
  output logic [2*W-1:0] add_opnd
);
  localparam int PW = 2 * W;

  logic            vld_q;
  unit_sel_e       sel_q;
  logic [W-1:0]    a_q, b_q;
  logic [NUM_UNITS-1:0]         iso_en;
  logic [NUM_UNITS-1:0][PW-1:0] iso_q;
  logic            gt;
  logic [W:0]      sum;

  gca_in_stage #(.W(W)) u_in (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel(sel),
    .a_in(a_in), .b_in(b_in),
    .vld_q(vld_q), .sel_q(sel_q), .a_q(a_q), .b_q(b_q)
  );

  // One latch bank per unit; index 0 feeds the comparator, 1 the adder.
  // Reset opens both banks so they settle to the cleared operands.
  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_iso
    localparam unit_sel_e OWN = (i == 0) ? UNIT_CMP : UNIT_ADD;
    always_comb iso_en[i] = rst | (vld_q & (sel_q == OWN));
    gca_iso_latch #(.DW(PW)) u_lat (
      .en(iso_en[i]), .d({a_q, b_q}), .q(iso_q[i])
    );
  end

  gca_gt_unit #(.W(W)) u_gt (
    .a(iso_q[0][PW-1:W]), .b(iso_q[0][W-1:0]), .gt(gt)
  );

  gca_sum_unit #(.W(W)) u_sum (
    .a(iso_q[1][PW-1:W]), .b(iso_q[1][W-1:0]), .sum(sum)
  );

  gca_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .vld_q(vld_q), .sel_q(sel_q),
    .gt(gt), .sum(sum), .res_out(res_out)
  );

  always_comb begin
    cmp_opnd = iso_q[0];
    add_opnd = iso_q[1];
  end
endmodule

// File: rtl/gca_chk.sv
module gca_chk
  import gca_pkg::*;
#(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           vld_q,
  input unit_sel_e      sel_q,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   b_q,
  input logic [W:0]     res_out,
  input logic [2*W-1:0] cmp_opnd,
  input logic [2*W-1:0] add_opnd
);
  // R5: comparator operands frozen unless a compare was captured
  p_cmp_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !(vld_q && sel_q == UNIT_CMP) |-> $stable(cmp_opnd));

  // R6: adder operands frozen unless an add was captured
  p_add_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    !(vld_q && sel_q == UNIT_ADD) |-> $stable(add_opnd));

  // R2: compare result one edge after capture
  p_cmp_res_r2: assert property (@(posedge clk) disable iff (rst)
    (vld_q && sel_q == UNIT_CMP) |=> res_out == {{W{1'b0}}, $past(a_q > b_q)});

  // R3: sum with carry one edge after capture
  p_add_res_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_q && sel_q == UNIT_ADD) |=> res_out == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}));

  // R8: result held when nothing was captured
  p_res_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !vld_q |=> $stable(res_out));

  // R9: reset clears the result
  p_rst_clear_r9: assert property (@(posedge clk)
    rst |=> res_out == '0);
endmodule

bind guarded_cmp_add gca_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .vld_q(vld_q), .sel_q(sel_q),
  .a_q(a_q), .b_q(b_q), .res_out(res_out),
  .cmp_opnd(cmp_opnd), .add_opnd(add_opnd)
);

// File: tb/guarded_cmp_add_tb.sv
module guarded_cmp_add_tb;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           sel = 1'b0;
  logic [W-1:0]   a_in = '0;
  logic [W-1:0]   b_in = '0;
  logic [W:0]     res_out;
  logic [2*W-1:0] cmp_opnd, add_opnd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // spec model state
  logic           m_vq = 0, m_sq = 0;
  logic [W-1:0]   m_a = '0, m_b = '0;
  logic [W:0]     m_res = '0;
  logic [2*W-1:0] m_cmp = '0, m_add = '0;
  logic           last_v = 0, last_s = 0;

  always #2 clk = ~clk;

  guarded_cmp_add #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sel(sel),
    .a_in(a_in), .b_in(b_in), .res_out(res_out),
    .cmp_opnd(cmp_opnd), .add_opnd(add_opnd)
  );

  function automatic logic [W:0] f_result(logic s, logic [W-1:0] a, logic [W-1:0] b);
    if (s) return {1'b0, a} + {1'b0, b};
    return {{W{1'b0}}, (a > b)};
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_w(string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at negedge, advance one edge, update model, check after edge
  task automatic step(logic v, logic s, logic [W-1:0] a, logic [W-1:0] b);
    logic pv, ps;
    in_valid = v; sel = s; a_in = a; b_in = b;
    @(posedge clk);
    pv = m_vq; ps = m_sq;
    if (m_vq) m_res = f_result(m_sq, m_a, m_b);
    m_vq = v;
    if (v) begin m_sq = s; m_a = a; m_b = b; end
    if (m_vq && !m_sq) m_cmp = {m_a, m_b};
    if (m_vq &&  m_sq) m_add = {m_a, m_b};
    @(negedge clk);
    if (!pv)     check("R8 result hold", res_out, m_res);
    else if (ps) check("R3 sum", res_out, m_res);
    else         check("R2 compare", res_out, m_res);
    if (v && !s) check_w("R7 R4 cmp operands", cmp_opnd, m_cmp);
    else         check_w("R5 cmp frozen", cmp_opnd, m_cmp);
    if (v && s)  check_w("R7 R4 add operands", add_opnd, m_add);
    else         check_w("R6 add frozen", add_opnd, m_add);
    last_v = v; last_s = s;
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd12345;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset result", res_out, '0);
    check_w("R9 reset cmp", cmp_opnd, '0);
    check_w("R9 reset add", add_opnd, '0);

    // directed corners
    step(1, 1, 8'hFF, 8'hFF);
    step(0, 0, 8'h00, 8'h00);
    check("R3 carry 255+255", res_out, 9'd510);
    step(1, 0, 8'h40, 8'h40);
    step(0, 1, 8'h11, 8'h22);
    check("R2 equal is zero", res_out, 9'd0);
    step(1, 0, 8'hFF, 8'h00);
    step(1, 0, 8'h00, 8'hFF);
    check("R2 255>0 unsigned", res_out, 9'd1);
    step(0, 1, 8'hAA, 8'h55);
    check("R2 0>255 unsigned", res_out, 9'd0);
    step(0, 1, 8'h77, 8'h01);
    check("R1 ignored inputs hold", res_out, 9'd0);
    check_w("R1 ignored adder operands", add_opnd, {8'hFF, 8'hFF});
    step(1, 1, 8'h00, 8'h00);
    step(1, 0, 8'h80, 8'h7F);
    check("R3 zero sum", res_out, 9'd0);

    // random mix, including long single-unit runs
    for (int i = 0; i < 400; i++) begin
      logic v, s;
      v = ($urandom % 4) != 0;
      s = (i % 100 < 30) ? 1'b0 : (i % 100 < 50) ? 1'b1 : 1'($urandom % 2);
      step(v, s, W'($urandom), W'($urandom));
    end
    step(0, 0, '0, '0);
    step(0, 0, '0, '0);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule